// File: doc/BRIEF.md
# Fracturable Eight-Input Logic Cell

This block models one configurable logic cell of a programmable fabric. Eight data inputs feed a 64-bit truth table. A mode field decides how the table and the inputs are divided. The table can act as one six-input function. It can also be cut into two smaller functions, with zero, one or two inputs shared between them. A further mode turns the cell into a two-bit adder with carry in and carry out. Two flip-flops, one per function output, can capture the function values. A per-output select bit chooses whether the registered or the live value reaches the registered output pins.

The whole configuration is written in parallel in one cycle: mode, truth table and the two output-select bits. It stays fixed until the next write. The synchronous clear empties both flip-flops and returns the configuration to all zeros. The clock enable gates the flip-flops only; it does not gate configuration writes.

Top module: `frac_logic_cell`

## Requirements
- R1: While `syncClr` is high at a clock edge, the configuration (mode, table, selects) and both flip-flops become zero. After clear, `combOut`, `regOut` and `carryOut` all read 0.
- R2: Mode 0 (whole) gives `combOut[0]` = table bit at index `dataIn[5:0]`, with `combOut[1]` = 0.
- R3: Mode 1 (pair of four-input functions) gives `combOut[0]` = table bit `dataIn[3:0]` and `combOut[1]` = table bit 32 + `dataIn[7:4]`.
- R4: Mode 2 (five plus three, no sharing) gives `combOut[0]` = table bit `dataIn[4:0]` and `combOut[1]` = table bit 32 + `dataIn[7:5]`.
- R5: Mode 3 (five plus four, one shared input) gives `combOut[0]` = table bit `dataIn[4:0]` and `combOut[1]` = table bit 32 + {`dataIn[7:5]`, `dataIn[0]`}.
- R6: Mode 4 (two five-input functions, two shared inputs) gives `combOut[0]` = table bit `dataIn[4:0]` and `combOut[1]` = table bit 32 + {`dataIn[7:5]`, `dataIn[1:0]`}.
- R7: Mode 5 (add) forms `dataIn[1:0]` + `dataIn[3:2]` + `carryIn` through two chained one-bit stages. Sum bit 0 goes to `combOut[0]`, sum bit 1 to `combOut[1]` and the final carry to `carryOut`. In every other mode `carryOut` is 0.
- R8: Modes 6 and 7 are reserved and drive `combOut` to 0 and `carryOut` to 0, whatever the table holds.
- R9: At a clock edge with `clkEn` high, flip-flop i takes `combOut[i]`. With `clkEn` low, it holds its value.
- R10: Bit i of the stored output select set to 1 puts flip-flop i on `regOut[i]`. Set to 0, it puts `combOut[i]` on `regOut[i]`.
- R11: Clear takes priority over `clkEn`: both flip-flops read 0 after a clear edge even with `clkEn` high.
- R12: The configuration changes only at an edge where `cfgLoad` is high. Values on `cfgMode`, `cfgTruth` and `cfgRegSel` at other edges have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| syncClr | input | 1 | Synchronous clear of flip-flops and configuration |
| clkEn | input | 1 | Capture enable for both flip-flops |
| cfgLoad | input | 1 | Writes the configuration fields at this edge |
| cfgMode | input | 3 | Mode value to store (0 to 5 defined, 6 and 7 reserved) |
| cfgTruth | input | 64 | Truth table to store; lower half serves function 0 in split modes, upper half function 1 |
| cfgRegSel | input | 2 | Output select per flip-flop, 1 = registered |
| dataIn | input | 8 | Shared data inputs |
| carryIn | input | 1 | Carry into the lower adder stage |
| combOut | output | 2 | Live function outputs |
| regOut | output | 2 | Registered or live output, by select bit |
| carryOut | output | 1 | Carry out of the upper adder stage |

## Verification
A wrong stored mode or table bit shows on `combOut` in the same cycle the data inputs address it, so a random table and data sweep across all eight mode values exposes a bad index or bad sharing rule at once. A flip-flop that captures on the wrong enable or misses a clear shows on `regOut` one edge later. The bench therefore reads `regOut` at the falling edge that follows each capture, and again after the configuration has changed under a held value. A configuration that leaks through without `cfgLoad` changes `combOut` one edge after the stray fields are driven.

// File: rtl/cell_pkg.sv
package cell_pkg;
  localparam int CELL_OUTS = 2;

  typedef enum logic [2:0] {
    MODE_WHOLE6     = 3'd0,
    MODE_PAIR4      = 3'd1,
    MODE_FIVE_THREE = 3'd2,
    MODE_FIVE_FOUR  = 3'd3,
    MODE_PAIR5      = 3'd4,
    MODE_ADD        = 3'd5
  } cellMode_e;

  typedef struct packed {
    logic                 routeWhole;
    logic                 routePair4;
    logic                 routeFiveThree;
    logic                 routeFiveFour;
    logic                 routePair5;
    logic                 routeAdd;
    logic [CELL_OUTS-1:0] capEn;
    logic                 capClr;
    logic [CELL_OUTS-1:0] passReg;
  } cellStrobes_t;
endpackage

// File: rtl/cell_ctrl.sv
module cell_ctrl
  import cell_pkg::*;
#(
  parameter int LUT_K = 6,
  localparam int TT_W = 1 << LUT_K
) (
  input  logic                 clk,
  input  logic                 syncClr,
  input  logic                 clkEn,
  input  logic                 cfgLoad,
  input  logic [2:0]           cfgMode,
  input  logic [TT_W-1:0]      cfgTruth,
  input  logic [CELL_OUTS-1:0] cfgRegSel,
  output logic [TT_W-1:0]      truthQ,
  output cellStrobes_t         strobes
);
  logic [2:0]           modeQ;
  logic [CELL_OUTS-1:0] regSelQ;

  always_ff @(posedge clk) begin
    if (syncClr) begin
      modeQ   <= '0;
      truthQ  <= '0;
      regSelQ <= '0;
    end else if (cfgLoad) begin
      modeQ   <= cfgMode;
      truthQ  <= cfgTruth;
      regSelQ <= cfgRegSel;
    end
  end

  always_comb begin
    strobes = '0;
    unique case (modeQ)
      MODE_WHOLE6:     strobes.routeWhole     = 1'b1;
      MODE_PAIR4:      strobes.routePair4     = 1'b1;
      MODE_FIVE_THREE: strobes.routeFiveThree = 1'b1;
      MODE_FIVE_FOUR:  strobes.routeFiveFour  = 1'b1;
      MODE_PAIR5:      strobes.routePair5     = 1'b1;
      MODE_ADD:        strobes.routeAdd       = 1'b1;
      default:         ;
    endcase
    strobes.capEn   = {CELL_OUTS{clkEn}};
    strobes.capClr  = syncClr;
    strobes.passReg = regSelQ;
  end

  // R12: configuration only moves on a write edge
  a_r12_cfg_hold: assert property (@(posedge clk) disable iff (syncClr)
    !cfgLoad |=> ($stable(truthQ) && $stable(modeQ) && $stable(regSelQ)));

  // R1: clear empties the configuration
  a_r1_cfg_clear: assert property (@(posedge clk)
    syncClr |=> (truthQ == '0 && modeQ == '0 && regSelQ == '0));
endmodule

// File: rtl/cell_datapath.sv
module cell_datapath
  import cell_pkg::*;
#(
  parameter int IN_W  = 8,
  parameter int LUT_K = 6,
  parameter int ADD_N = 2,
  localparam int TT_W   = 1 << LUT_K,
  localparam int HALF_W = TT_W / 2,
  localparam int HIDX_W = LUT_K - 1
) (
  input  logic                 clk,
  input  logic [IN_W-1:0]      dataIn,
  input  logic                 carryIn,
  input  logic [TT_W-1:0]      truth,
  input  cellStrobes_t         strobes,
  output logic [CELL_OUTS-1:0] combOut,
  output logic [CELL_OUTS-1:0] regOut,
  output logic                 carryOut
);
  logic [HALF_W-1:0]    loHalf, hiHalf;
  logic [LUT_K-1:0]     idxWhole;
  logic [HIDX_W-1:0]    idxLo, idxHi;
  logic [ADD_N:0]       carryChain;
  logic [ADD_N-1:0]     sumBits;
  logic [CELL_OUTS-1:0] capQ;
  logic                 anySplit, anyRoute;

  assign loHalf   = truth[HALF_W-1:0];
  assign hiHalf   = truth[TT_W-1:HALF_W];
  assign idxWhole = dataIn[LUT_K-1:0];
  assign anySplit = strobes.routePair4 | strobes.routeFiveThree |
                    strobes.routeFiveFour | strobes.routePair5;
  assign anyRoute = anySplit | strobes.routeWhole | strobes.routeAdd;

  // lower function index: four or five private inputs from the bottom
  assign idxLo = strobes.routePair4 ? {1'b0, dataIn[3:0]} : dataIn[4:0];

  // upper function index: sharing rule differs per split mode
  always_comb begin
    idxHi = '0;
    if (strobes.routePair4)          idxHi = {1'b0, dataIn[7:4]};
    else if (strobes.routeFiveThree) idxHi = {2'b00, dataIn[7:5]};
    else if (strobes.routeFiveFour)  idxHi = {1'b0, dataIn[7:5], dataIn[0]};
    else if (strobes.routePair5)     idxHi = {dataIn[7:5], dataIn[1:0]};
  end

  // chained one-bit adder stages
  assign carryChain[0] = carryIn;
  for (genvar g = 0; g < ADD_N; g++) begin : g_add
    logic opA, opB;
    assign opA = dataIn[g];
    assign opB = dataIn[ADD_N + g];
    assign sumBits[g]      = opA ^ opB ^ carryChain[g];
    assign carryChain[g+1] = (opA & opB) | (carryChain[g] & (opA ^ opB));
  end

  always_comb begin
    combOut = '0;
    if (strobes.routeWhole) begin
      combOut[0] = truth[idxWhole];
    end else if (strobes.routeAdd) begin
      combOut = sumBits[CELL_OUTS-1:0];
    end else if (anySplit) begin
      combOut[0] = loHalf[idxLo];
      combOut[1] = hiHalf[idxHi];
    end
  end

  assign carryOut = strobes.routeAdd & carryChain[ADD_N];

  for (genvar i = 0; i < CELL_OUTS; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (strobes.capClr)      capQ[i] <= 1'b0;
      else if (strobes.capEn[i]) capQ[i] <= combOut[i];
    end
    assign regOut[i] = strobes.passReg[i] ? capQ[i] : combOut[i];

    // R9: capture follows the live value of the previous edge
    a_r9_capture: assert property (@(posedge clk) disable iff (strobes.capClr)
      strobes.capEn[i] |=> (capQ[i] == $past(combOut[i])));
    // R9: no enable, no change
    a_r9_hold: assert property (@(posedge clk) disable iff (strobes.capClr)
      !strobes.capEn[i] |=> $stable(capQ[i]));
    // R11: clear wins over enable
    a_r11_clear: assert property (@(posedge clk)
      strobes.capClr |=> (capQ[i] == 1'b0));
  end

  // R8: reserved modes drive nothing
  a_r8_reserved: assert property (@(posedge clk) disable iff (strobes.capClr)
    !anyRoute |-> (combOut == '0 && carryOut == 1'b0));
  // R7: carry port quiet outside add mode
  a_r7_carry_quiet: assert property (@(posedge clk) disable iff (strobes.capClr)
    !strobes.routeAdd |-> (carryOut == 1'b0));
endmodule

// File: rtl/frac_logic_cell.sv
module frac_logic_cell
  import cell_pkg::*;
#(
  parameter int IN_W  = 8,
  parameter int LUT_K = 6,
  localparam int TT_W = 1 << LUT_K
) (
  input  logic                 clk,
  input  logic                 syncClr,
  input  logic                 clkEn,
  input  logic                 cfgLoad,
  input  logic [2:0]           cfgMode,
  input  logic [TT_W-1:0]      cfgTruth,
  input  logic [CELL_OUTS-1:0] cfgRegSel,
  input  logic [IN_W-1:0]      dataIn,
  input  logic                 carryIn,
  output logic [CELL_OUTS-1:0] combOut,
  output logic [CELL_OUTS-1:0] regOut,
  output logic                 carryOut
);
  cellStrobes_t     strobes;
  logic [TT_W-1:0]  truthQ;

  cell_ctrl #(.LUT_K(LUT_K)) ctrl_i (
    .clk       (clk),
    .syncClr   (syncClr),
    .clkEn     (clkEn),
    .cfgLoad   (cfgLoad),
    .cfgMode   (cfgMode),
    .cfgTruth  (cfgTruth),
    .cfgRegSel (cfgRegSel),
    .truthQ    (truthQ),
    .strobes   (strobes)
  );

  cell_datapath #(.IN_W(IN_W), .LUT_K(LUT_K), .ADD_N(2)) dp_i (
    .clk      (clk),
    .dataIn   (dataIn),
    .carryIn  (carryIn),
    .truth    (truthQ),
    .strobes  (strobes),
    .combOut  (combOut),
    .regOut   (regOut),
    .carryOut (carryOut)
  );
endmodule

// File: tb/frac_logic_cell_tb.sv
module frac_logic_cell_tb_top;
  logic        clk = 1'b0;
  logic        syncClr, clkEn, cfgLoad, carryIn;
  logic [2:0]  cfgMode;
  logic [63:0] cfgTruth;
  logic [1:0]  cfgRegSel, combOut, regOut;
  logic [7:0]  dataIn;
  logic        carryOut;
  int          total = 0;
  int          bad   = 0;
  bit          finished = 0;

  always #4 clk = ~clk;

  frac_logic_cell dut_i (
    .clk(clk), .syncClr(syncClr), .clkEn(clkEn), .cfgLoad(cfgLoad),
    .cfgMode(cfgMode), .cfgTruth(cfgTruth), .cfgRegSel(cfgRegSel),
    .dataIn(dataIn), .carryIn(carryIn), .combOut(combOut),
    .regOut(regOut), .carryOut(carryOut)
  );

  typedef struct packed {
    logic [2:0]  mode;
    logic [63:0] tt;
    logic [7:0]  d;
    logic        cin;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 64'h8000_0000_0000_0001, 8'h3F, 1'b0},
    '{3'd0, 64'h8000_0000_0000_0001, 8'h00, 1'b0},
    '{3'd0, 64'hF0F0_1234_A5A5_0FF0, 8'hC7, 1'b1},
    '{3'd1, 64'h0000_8001_0000_0001, 8'hF0, 1'b0},
    '{3'd1, 64'hDEAD_BEEF_0BAD_F00D, 8'h5A, 1'b0},
    '{3'd2, 64'h0000_0080_8000_0000, 8'hFF, 1'b0},
    '{3'd2, 64'h1357_9BDF_2468_ACE0, 8'hA3, 1'b0},
    '{3'd3, 64'h0000_0002_0000_0000, 8'h01, 1'b0},
    '{3'd3, 64'h0000_0001_0000_0000, 8'h01, 1'b0},
    '{3'd4, 64'h0000_0008_0000_0000, 8'h03, 1'b0},
    '{3'd4, 64'hCAFE_F00D_0123_4567, 8'h6E, 1'b0},
    '{3'd5, 64'hFFFF_FFFF_FFFF_FFFF, 8'h0F, 1'b1},
    '{3'd6, 64'hFFFF_FFFF_FFFF_FFFF, 8'hFF, 1'b1},
    '{3'd7, 64'hFFFF_FFFF_FFFF_FFFF, 8'h0F, 1'b1}
  };

  // expected {carry, f1, f0} from the requirement text
  function automatic logic [2:0] model(input logic [2:0] m, input logic [63:0] tt,
                                       input logic [7:0] d, input logic c);
    logic [2:0] r;
    logic [2:0] s;
    r = '0;
    case (m)
      3'd0: r[0] = tt[d[5:0]];
      3'd1: begin r[0] = tt[d[3:0]]; r[1] = tt[32 + int'(d[7:4])]; end
      3'd2: begin r[0] = tt[d[4:0]]; r[1] = tt[32 + int'(d[7:5])]; end
      3'd3: begin r[0] = tt[d[4:0]]; r[1] = tt[32 + int'({d[7:5], d[0]})]; end
      3'd4: begin r[0] = tt[d[4:0]]; r[1] = tt[32 + int'({d[7:5], d[1:0]})]; end
      3'd5: begin s = {1'b0, d[1:0]} + {1'b0, d[3:2]} + {2'b00, c}; r = s; end
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic string tagOf(input logic [2:0] m);
    case (m)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R6";
      3'd5: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [2:0] got, input logic [2:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got=%b expected=%b", tag, got, exp);
    end
  endtask

  task automatic applyCfg(input logic [2:0] m, input logic [63:0] tt, input logic [1:0] sel);
    @(negedge clk);
    cfgMode = m; cfgTruth = tt; cfgRegSel = sel; cfgLoad = 1'b1;
    @(negedge clk);
    cfgLoad = 1'b0;
  endtask

  task automatic checkComb(input logic [2:0] m, input logic [63:0] tt,
                           input logic [7:0] d, input logic c);
    dataIn = d; carryIn = c;
    #1;
    chk(tagOf(m), {carryOut, combOut}, model(m, tt, d, c));
  endtask

  initial begin
    syncClr = 1'b1; clkEn = 1'b0; cfgLoad = 1'b0; carryIn = 1'b0;
    cfgMode = 3'd2; cfgTruth = '1; cfgRegSel = 2'b11; dataIn = 8'hFF;
    repeat (3) @(negedge clk);
    #1;
    // R1: reset state
    chk("R1 comb/carry", {carryOut, combOut}, 3'b000);
    chk("R1 reg", {1'b0, regOut}, 3'b000);
    syncClr = 1'b0;

    // table walk, select = live path
    for (int i = 0; i < NV; i++) begin
      applyCfg(VECS[i].mode, VECS[i].tt, 2'b00);
      checkComb(VECS[i].mode, VECS[i].tt, VECS[i].d, VECS[i].cin);
      chk("R10 live path", {1'b0, regOut}, {1'b0, combOut});
    end

    // random sweep with capture check
    for (int k = 0; k < 150; k++) begin
      logic [2:0]  m;
      logic [63:0] tt;
      logic [7:0]  d;
      logic        c;
      logic [2:0]  e;
      m  = 3'($urandom_range(0, 7));
      tt = {$urandom, $urandom};
      d  = 8'($urandom);
      c  = 1'($urandom);
      e  = model(m, tt, d, c);
      applyCfg(m, tt, 2'b11);
      checkComb(m, tt, d, c);
      clkEn = 1'b1;
      @(negedge clk);
      clkEn = 1'b0;
      #1;
      chk("R9 capture", {1'b0, regOut}, {1'b0, e[1:0]});
    end

    // R9 hold with enable low while configuration changes underneath
    applyCfg(3'd0, '1, 2'b11);
    dataIn = 8'h00; clkEn = 1'b1;
    @(negedge clk);
    clkEn = 1'b0;
    applyCfg(3'd0, '0, 2'b11);
    #1;
    chk("R9 hold", {1'b0, regOut}, 3'b001);
    chk("R10 registered differs from live", {1'b0, combOut}, 3'b000);
    applyCfg(3'd0, '0, 2'b00);
    #1;
    chk("R10 select live", {1'b0, regOut}, 3'b000);

    // R11: clear beats enable
    applyCfg(3'd0, '1, 2'b11);
    clkEn = 1'b1;
    @(negedge clk);
    #1;
    chk("R11 pre-clear capture", {1'b0, regOut}, 3'b001);
    syncClr = 1'b1;
    @(negedge clk);
    syncClr = 1'b0; clkEn = 1'b0;
    #1;
    chk("R11 clear over enable", {1'b0, regOut}, 3'b000);
    chk("R1 config cleared", {carryOut, combOut}, 3'b000);

    // R7 adder corners
    applyCfg(3'd5, '0, 2'b00);
    checkComb(3'd5, '0, 8'h00, 1'b0);
    chk("R7 zero", {carryOut, combOut}, 3'b000);
    checkComb(3'd5, '0, 8'h0F, 1'b1);
    chk("R7 3+3+1", {carryOut, combOut}, 3'b111);
    checkComb(3'd5, '0, 8'h06, 1'b1);
    chk("R7 2+1+1", {carryOut, combOut}, 3'b100);

    // R12: fields without a write strobe are ignored
    @(negedge clk);
    cfgMode = 3'd7; cfgTruth = '1; cfgRegSel = 2'b11; cfgLoad = 1'b0;
    dataIn = 8'h0F; carryIn = 1'b1;
    @(negedge clk);
    #1;
    chk("R12 no write", {carryOut, combOut}, 3'b111);
    chk("R12 select unchanged", {1'b0, regOut}, {1'b0, combOut});

    // R8 reserved with a full table
    applyCfg(3'd6, '1, 2'b00);
    checkComb(3'd6, '1, 8'hFF, 1'b1);
    chk("R8 reserved six", {carryOut, combOut}, 3'b000);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: got=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule